// File: doc/BRIEF.md
# Two-Slot Instruction Prefetch Buffer

This block sits between the instruction-fetch port of a CPU and a memory read port that can deliver bursts. It keeps the 16-bit instruction stream close to the core in two slots of eight halfwords each, so straight-line code and short loops are fed without going to memory for every fetch. A fetch that finds its word in a valid slot is answered on the next cycle. A fetch that does not find it starts an eight-word burst from the aligned start of its line. The block writes the burst into one slot and forwards the requested halfword as it goes by. The CPU is held with a wait signal until the burst ends.

The address is split into three fields. Byte address bits [3:1] pick the halfword within a slot. Bits [13:4] are a line tag kept separately for each slot. Bits [24:14] form a single upper tag that both slots share. Misses fill slot 0 first, then slot 1, then slot 0 again, and so on, with no usage tracking. When the enable input is low the buffer is bypassed: every fetch becomes a single-word read at its exact address, and both slots are marked empty.

Top module: `iqbuf_top`

## Requirements
- R1: After reset, cpu_wait, cpu_rvalid and mem_req are 0. Both slots are empty, so the first enabled fetch is a miss.
- R2: When en is 0, an accepted fetch issues one request with mem_burst=0 at the exact fetch address. It returns the single word delivered, and repeating the same fetch reads memory again.
- R3: On a miss with en=1, mem_req rises one cycle after acceptance with mem_burst=1 and mem_addr equal to the fetch address with bits [3:0] cleared. cpu_wait is 1 from that cycle until the cycle after the eighth memory word.
- R4: During a fill, memory word k (counted from 0 in arrival order) belongs to halfword offset k. cpu_rvalid pulses one cycle after the word whose index equals fetch address bits [3:1], and carries that word.
- R5: A fetch that hits returns the stored word with cpu_rvalid one cycle after acceptance. It raises no mem_req and leaves cpu_wait at 0.
- R6: Fills go to the two slots strictly alternately. A third distinct line evicts the first one and keeps the second.
- R7: A miss whose bits [24:14] differ from the stored upper tag replaces that tag and empties the other slot, so that slot's line misses afterwards.
- R8: A fetch hits only when the slot's line tag equals bits [13:4] and the upper tag equals bits [24:14]. Any offset within a filled line hits, and at most one slot matches.
- R9: A fetch is accepted only in a cycle where cpu_req is 1 and cpu_wait is 0. A request held during a fill is taken only after the fill completes, and mem_req never rises while cpu_wait is 0.
- R10: Driving en to 0 empties both slots, so after en returns to 1 a previously filled line misses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Buffer enable; 0 selects bypass and empties the slots |
| cpu_req | input | 1 | Fetch request, taken when cpu_wait is 0 |
| cpu_addr | input | 25 | Fetch byte address |
| cpu_wait | output | 1 | CPU stall while a memory access is in flight |
| cpu_rvalid | output | 1 | One-cycle pulse marking cpu_rdata valid |
| cpu_rdata | output | 16 | Returned instruction halfword |
| mem_req | output | 1 | One-cycle memory read request |
| mem_burst | output | 1 | 1: eight-word burst; 0: single word |
| mem_addr | output | 25 | Memory read byte address |
| mem_rvalid | input | 1 | Memory data valid, one pulse per word |
| mem_rdata | input | 16 | Memory read data |

## Verification
The assertions check on every cycle that each accepted fetch has the right immediate effect. A hit answers at once without a memory request. A miss starts an aligned burst and stalls the CPU. A bypass fetch starts a single read. Requests come only as single pulses during a stall, and no two slots match the same address. Only the bench scenarios can show what depends on history: which slot a fill evicts under alternation, the loss of the other slot when the upper tag changes, the emptying on disable, the cycle the requested offset is forwarded in, and whether a held request waits out the whole burst.

// File: rtl/iqbuf_pkg.sv
package iqbuf_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FILL = 2'd1,
    ST_PASS = 2'd2
  } iqbuf_st_e;
endpackage

// File: rtl/iqbuf_tags.sv
// Tag store: per-slot line tags, one shared upper tag, valid flags and the
// alternating fill pointer.
module iqbuf_tags #(
  parameter int LINE_W = 10,
  parameter int UP_W   = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [LINE_W-1:0] lk_line,
  input  logic [UP_W-1:0]   lk_up,
  input  logic              fill_start,
  input  logic              fill_done,
  output logic [1:0]        slot_hit,
  output logic              hit,
  output logic              hit_slot,
  output logic              nxt_slot
);
  logic [1:0]        vld;
  logic [LINE_W-1:0] line_q [2];
  logic [UP_W-1:0]   up_q;
  logic              nxt;

  generate
    for (genvar s = 0; s < 2; s++) begin : g_cmp
      assign slot_hit[s] = vld[s] && (line_q[s] == lk_line) && (up_q == lk_up);
    end
  endgenerate

  assign hit      = |slot_hit;
  assign hit_slot = slot_hit[1];
  assign nxt_slot = nxt;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      vld <= '0;
      nxt <= 1'b0;
      if (rst) begin
        up_q      <= '0;
        line_q[0] <= '0;
        line_q[1] <= '0;
      end
    end else begin
      if (fill_start) begin
        vld[nxt]    <= 1'b0;
        line_q[nxt] <= lk_line;
        up_q        <= lk_up;
        if (up_q != lk_up) vld[~nxt] <= 1'b0;
      end
      if (fill_done) begin
        vld[nxt] <= 1'b1;
        nxt      <= ~nxt;
      end
    end
  end
endmodule

// File: rtl/iqbuf_store.sv
// Slot storage: one write port, registered read port (block RAM friendly).
module iqbuf_store #(
  parameter int DW = 16,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] ram [DEPTH];

  always_ff @(posedge clk) begin
    if (we) ram[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata <= ram[raddr];
  end
endmodule

// File: rtl/iqbuf_ctrl.sv
// Fetch acceptance, miss/bypass sequencing and the wait handshake.
module iqbuf_ctrl
  import iqbuf_pkg::*;
#(
  parameter int ADDR_W = 25,
  parameter int DATA_W = 16,
  parameter int OFS_W  = 3,
  parameter int LO     = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              cpu_req,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              hit,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              cpu_wait,
  output logic              cpu_rvalid,
  output logic              sel_ram,
  output logic [DATA_W-1:0] data_q,
  output logic              mem_req,
  output logic              mem_burst,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              fill_start,
  output logic              fill_done,
  output logic              wr_en,
  output logic [OFS_W-1:0]  wr_ofs
);
  localparam int ALIGN = LO + OFS_W;
  localparam logic [OFS_W-1:0] LAST = {OFS_W{1'b1}};

  iqbuf_st_e        st;
  logic [OFS_W-1:0] cnt;
  logic [OFS_W-1:0] ofs_q;
  logic             accept;

  assign accept     = cpu_req && !cpu_wait && (st == ST_IDLE);
  assign fill_start = accept && en && !hit;
  assign wr_en      = (st == ST_FILL) && mem_rvalid;
  assign wr_ofs     = cnt;
  assign fill_done  = wr_en && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      cpu_wait   <= 1'b0;
      cpu_rvalid <= 1'b0;
      sel_ram    <= 1'b0;
      data_q     <= '0;
      mem_req    <= 1'b0;
      mem_burst  <= 1'b0;
      mem_addr   <= '0;
      cnt        <= '0;
      ofs_q      <= '0;
    end else begin
      cpu_rvalid <= 1'b0;
      mem_req    <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (accept) begin
            if (!en) begin
              st        <= ST_PASS;
              cpu_wait  <= 1'b1;
              mem_req   <= 1'b1;
              mem_burst <= 1'b0;
              mem_addr  <= cpu_addr;
            end else if (hit) begin
              cpu_rvalid <= 1'b1;
              sel_ram    <= 1'b1;
            end else begin
              st        <= ST_FILL;
              cpu_wait  <= 1'b1;
              mem_req   <= 1'b1;
              mem_burst <= 1'b1;
              mem_addr  <= {cpu_addr[ADDR_W-1:ALIGN], {ALIGN{1'b0}}};
              cnt       <= '0;
              ofs_q     <= cpu_addr[ALIGN-1:LO];
            end
          end
        end
        ST_FILL: begin
          if (mem_rvalid) begin
            cnt <= cnt + 1'b1;
            if (cnt == ofs_q) begin
              cpu_rvalid <= 1'b1;
              sel_ram    <= 1'b0;
              data_q     <= mem_rdata;
            end
            if (cnt == LAST) begin
              st       <= ST_IDLE;
              cpu_wait <= 1'b0;
            end
          end
        end
        ST_PASS: begin
          if (mem_rvalid) begin
            st         <= ST_IDLE;
            cpu_wait   <= 1'b0;
            cpu_rvalid <= 1'b1;
            sel_ram    <= 1'b0;
            data_q     <= mem_rdata;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/iqbuf_top.sv
module iqbuf_top #(
  parameter int ADDR_W = 25,
  parameter int DATA_W = 16,
  parameter int OFS_W  = 3,
  parameter int LINE_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              cpu_req,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic              cpu_wait,
  output logic              cpu_rvalid,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              mem_req,
  output logic              mem_burst,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int LO      = $clog2(DATA_W / 8);
  localparam int LINE_LO = LO + OFS_W;
  localparam int UP_LO   = LINE_LO + LINE_W;
  localparam int UP_W    = ADDR_W - UP_LO;
  localparam int RA_W    = OFS_W + 1;

  logic [1:0]        slot_hit;
  logic              hit;
  logic              hit_slot;
  logic              nxt_slot;
  logic              fill_start;
  logic              fill_done;
  logic              wr_en;
  logic [OFS_W-1:0]  wr_ofs;
  logic              sel_ram;
  logic [DATA_W-1:0] data_q;
  logic [DATA_W-1:0] ram_q;

  iqbuf_tags #(.LINE_W(LINE_W), .UP_W(UP_W)) u_tags (
    .clk        (clk),
    .rst        (rst),
    .en         (en),
    .lk_line    (cpu_addr[UP_LO-1:LINE_LO]),
    .lk_up      (cpu_addr[ADDR_W-1:UP_LO]),
    .fill_start (fill_start),
    .fill_done  (fill_done),
    .slot_hit   (slot_hit),
    .hit        (hit),
    .hit_slot   (hit_slot),
    .nxt_slot   (nxt_slot)
  );

  iqbuf_store #(.DW(DATA_W), .AW(RA_W)) u_store (
    .clk   (clk),
    .we    (wr_en),
    .waddr ({nxt_slot, wr_ofs}),
    .wdata (mem_rdata),
    .raddr ({hit_slot, cpu_addr[LINE_LO-1:LO]}),
    .rdata (ram_q)
  );

  iqbuf_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFS_W(OFS_W), .LO(LO)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .en         (en),
    .cpu_req    (cpu_req),
    .cpu_addr   (cpu_addr),
    .hit        (hit),
    .mem_rvalid (mem_rvalid),
    .mem_rdata  (mem_rdata),
    .cpu_wait   (cpu_wait),
    .cpu_rvalid (cpu_rvalid),
    .sel_ram    (sel_ram),
    .data_q     (data_q),
    .mem_req    (mem_req),
    .mem_burst  (mem_burst),
    .mem_addr   (mem_addr),
    .fill_start (fill_start),
    .fill_done  (fill_done),
    .wr_en      (wr_en),
    .wr_ofs     (wr_ofs)
  );

  assign cpu_rdata = sel_ram ? ram_q : data_q;
endmodule

// File: rtl/iqbuf_chk.sv
module iqbuf_chk (
  input logic       clk,
  input logic       rst,
  input logic       en,
  input logic       cpu_req,
  input logic       cpu_wait,
  input logic       cpu_rvalid,
  input logic       mem_req,
  input logic       mem_burst,
  input logic       mem_aligned,
  input logic       hit,
  input logic [1:0] slot_hit
);
  // R5: a hit is answered next cycle with no memory traffic and no stall
  assert_hit_fast_R5: assert property (@(posedge clk) disable iff (rst)
    (cpu_req && !cpu_wait && en && hit) |=> (cpu_rvalid && !mem_req && !cpu_wait));

  // R3: a miss starts an aligned burst and stalls the CPU
  assert_miss_burst_R3: assert property (@(posedge clk) disable iff (rst)
    (cpu_req && !cpu_wait && en && !hit) |=> (mem_req && mem_burst && mem_aligned && cpu_wait));

  // R2: bypass fetch is a single-word read
  assert_bypass_single_R2: assert property (@(posedge clk) disable iff (rst)
    (cpu_req && !cpu_wait && !en) |=> (mem_req && !mem_burst && cpu_wait));

  // R9: memory is only requested while the CPU is held
  assert_req_stalls_R9: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> cpu_wait);

  // R9: a request is a single-cycle pulse
  assert_req_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> !mem_req);

  // R8: never two slots matching one address
  assert_unique_hit_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(slot_hit));
endmodule

bind iqbuf_top iqbuf_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .en          (en),
  .cpu_req     (cpu_req),
  .cpu_wait    (cpu_wait),
  .cpu_rvalid  (cpu_rvalid),
  .mem_req     (mem_req),
  .mem_burst   (mem_burst),
  .mem_aligned (mem_addr[LINE_LO-1:0] == '0),
  .hit         (hit),
  .slot_hit    (slot_hit)
);

// File: tb/iqbuf_top_bench.sv
`timescale 1ns/1ps
module iqbuf_top_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic        cpu_req = 1'b0;
  logic [24:0] cpu_addr = '0;
  logic        cpu_wait;
  logic        cpu_rvalid;
  logic [15:0] cpu_rdata;
  logic        mem_req;
  logic        mem_burst;
  logic [24:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [15:0] mem_rdata = '0;

  int n_chk = 0;
  int n_fail = 0;
  int mreq_cnt = 0;
  int beats = 0;
  logic [24:0] last_addr = '0;
  logic        last_burst = 1'b0;
  logic [15:0] exp_q[$];
  int          expb_q[$];

  always #2 clk = ~clk;

  iqbuf_top u_iqbuf_top (
    .clk(clk), .rst(rst), .en(en), .cpu_req(cpu_req), .cpu_addr(cpu_addr),
    .cpu_wait(cpu_wait), .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata),
    .mem_req(mem_req), .mem_burst(mem_burst), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  function automatic logic [15:0] wordf(input logic [24:0] a);
    return a[16:1] ^ {5'b0, a[24:14]} ^ 16'h5A3C;
  endfunction

  task automatic check(input bit ok, input string rq, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  // memory model: latency 2, one idle gap after word 2
  initial begin
    logic [24:0] a;
    int n;
    forever begin
      @(posedge clk);
      if (mem_req) begin
        a = mem_addr; n = mem_burst ? 8 : 1;
        last_addr = mem_addr; last_burst = mem_burst; mreq_cnt++;
        @(negedge clk); @(negedge clk);
        for (int i = 0; i < n; i++) begin
          mem_rvalid = 1'b1; mem_rdata = wordf(a + 25'(2 * i));
          @(negedge clk);
          if (i == 2) begin mem_rvalid = 1'b0; @(negedge clk); end
        end
        mem_rvalid = 1'b0;
      end
    end
  end

  always @(posedge clk) if (mem_rvalid) beats++;

  // monitor: pops the scoreboard on every returned word
  always @(negedge clk) begin
    if (cpu_rvalid) begin
      if (exp_q.size() == 0) begin
        check(0, "R4", "unexpected cpu_rvalid", 1, 0);
      end else begin
        logic [15:0] e; int eb;
        e = exp_q.pop_front(); eb = expb_q.pop_front();
        check(cpu_rdata == e, "R4", "returned word", int'(cpu_rdata), int'(e));
        if (eb >= 0) check(beats == eb, "R4", "forwarded after word index", beats, eb);
      end
    end
  end

  task automatic issue(input logic [24:0] a);
    @(negedge clk);
    cpu_req = 1'b1; cpu_addr = a;
    while (cpu_wait) @(negedge clk);
    @(posedge clk);
  endtask

  // kind: 0 hit, 1 miss, 2 bypass
  task automatic fetch(input logic [24:0] a, input int kind, input string rq);
    int m0;
    exp_q.push_back(wordf(a));
    expb_q.push_back(kind == 1 ? int'(a[3:1]) + 1 : -1);
    m0 = mreq_cnt;
    issue(a);
    beats = 0;
    @(negedge clk);
    cpu_req = 1'b0;
    if (kind == 0) begin
      check(cpu_rvalid, rq, "hit answered next cycle", int'(cpu_rvalid), 1);
      check(!cpu_wait, rq, "no stall on hit", int'(cpu_wait), 0);
    end
    while (cpu_wait) @(negedge clk);
    #1;
    check(mreq_cnt - m0 == (kind == 0 ? 0 : 1), rq, "memory requests", mreq_cnt - m0,
          kind == 0 ? 0 : 1);
    if (kind == 1) begin
      check(last_burst && last_addr == {a[24:4], 4'b0}, rq, "aligned burst address",
            int'(last_addr), int'({a[24:4], 4'b0}));
      check(beats == 8, "R3", "wait held until last word", beats, 8);
    end
    if (kind == 2) begin
      check(!last_burst && last_addr == a, rq, "exact single address",
            int'(last_addr), int'(a));
      check(beats == 1, rq, "single word", beats, 1);
    end
    check(exp_q.size() == 0, rq, "word delivered", exp_q.size(), 0);
  endtask

  localparam logic [24:0] A = 25'h0000120;
  localparam logic [24:0] B = 25'h0000130;
  localparam logic [24:0] C = 25'h0000140;
  localparam logic [24:0] D = 25'h1FFC120;
  localparam logic [24:0] E = 25'h0000200;

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    check(!cpu_wait && !cpu_rvalid && !mem_req, "R1", "idle outputs after reset",
          int'({cpu_wait, cpu_rvalid, mem_req}), 0);
    en = 1'b1;
    fetch(A + 6, 1, "R1");            // first fetch misses, slot 0
    fetch(A + 0, 0, "R5");
    fetch(A + 14, 0, "R8");
    fetch(B + 14, 1, "R8");           // other line misses, slot 1
    fetch(A + 2, 0, "R6");
    fetch(B + 0, 0, "R6");
    fetch(C + 0, 1, "R6");            // evicts A (slot 0)
    fetch(B + 4, 0, "R6");
    fetch(A + 8, 1, "R6");            // evicts B (slot 1)
    fetch(C + 2, 0, "R6");
    fetch(D + 4, 1, "R7");            // new upper tag, empties slot 1
    fetch(D + 2, 0, "R7");
    fetch(A + 0, 1, "R7");
    fetch(D + 6, 1, "R7");
    // R9: request held through a fill
    begin
      int m0;
      exp_q.push_back(wordf(E + 2)); expb_q.push_back(2);
      exp_q.push_back(wordf(E + 10)); expb_q.push_back(-1);
      m0 = mreq_cnt;
      issue(E + 2);
      beats = 0;
      @(negedge clk);
      cpu_addr = E + 10;
      check(cpu_wait, "R9", "second request stalled", int'(cpu_wait), 1);
      while (cpu_wait) @(negedge clk);
      check(beats == 8, "R9", "held request taken after fill", beats, 8);
      check(exp_q.size() == 1, "R9", "only first word returned", exp_q.size(), 1);
      @(posedge clk);
      @(negedge clk);
      cpu_req = 1'b0;
      check(cpu_rvalid, "R9", "held request served as hit", int'(cpu_rvalid), 1);
      #1;
      check(mreq_cnt - m0 == 1, "R9", "one memory request", mreq_cnt - m0, 1);
    end
    @(negedge clk) en = 1'b0;
    repeat (3) @(negedge clk);
    en = 1'b1;
    fetch(E + 0, 1, "R10");
    @(negedge clk) en = 1'b0;
    fetch(A + 6, 2, "R2");
    fetch(A + 6, 2, "R2");
    en = 1'b1;
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0 && !cpu_rvalid, "R4", "no stray words", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule